// File: doc/BRIEF.md
# Binary32 / Binary64 Format Converter

The block turns a floating-point operand held in a 64-bit register into the other IEEE 754 binary format. It widens binary32 to binary64 and narrows binary64 to binary32. A conversion request is taken whenever `in_valid` is high. The result and its four exception flags are registered and come out with `out_valid` on the next cycle. The caller chooses the direction through two separate format selects, one for the source and one for the destination.

A binary32 value inside the 64-bit register counts as valid only when the upper half of the register is all ones. Any other binary32 source is replaced by the binary32 canonical NaN before it is converted. Every binary32 result is written to the low half of the register, and the upper half is filled with ones. Widening is always exact. Narrowing rounds by a 3-bit rounding mode, and it handles overflow, gradual underflow and binary64 subnormal inputs.

Top module: `fpcvt_sd`

## Requirements
- R1: Each request accepted with `in_valid` high produces `out_valid` high on the next rising edge, carrying the result and flags of that request. In any cycle after a cycle with `in_valid` low, `out_valid` is low and `result` and the flags keep their previous values. After reset all outputs are zero.
- R2: A format select of 1 means binary64 and 0 means binary32. When `src_is_dbl` equals `dst_is_dbl`, the result is the canonical NaN of that format, boxed when the format is binary32. Only `fx_nv` is raised.
- R3: Widening (src 0, dst 1) keeps the value exactly. It keeps the sign of zeros and infinities, and it turns binary32 subnormals into binary64 normals. It never raises `fx_nx`, `fx_of` or `fx_uf`. It ignores `rnd_mode`, including the illegal codes.
- R4: A binary32 source whose bits 63:32 are not all ones is converted as the binary32 canonical NaN. Widening such a source gives 0x7FF8000000000000 with no flags.
- R5: Any NaN source gives the canonical NaN of the destination format: 0x7FF8000000000000 for binary64, or 0xFFFFFFFF_7FC00000 for binary32. `fx_nv` is raised only when the source is a signaling NaN, that is, when the top fraction bit is 0.
- R6: Every binary32 result has bits 63:32 set to all ones.
- R7: Narrowing rounds by `rnd_mode`: 000 to nearest with ties to even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 to nearest with ties away from zero. `fx_nx` is raised when the result differs from the source.
- R8: When narrowing with `rnd_mode` 101, 110 or 111, the result is the boxed binary32 canonical NaN and only `fx_nv` is raised.
- R9: A finite narrowing whose rounded magnitude does not fit in binary32 raises `fx_of` and `fx_nx`. The result is infinity under the two nearest modes, or when the directed mode rounds away from zero. Otherwise the result is the largest finite value, with the source's sign.
- R10: A narrowing whose source magnitude is below 2^-126 before rounding is tiny. It is denormalized with correct rounding and may round up to the smallest normal. `fx_uf` is raised exactly when a tiny result is also inexact.
- R11: Binary64 subnormal sources narrow to a signed zero, or to the smallest binary32 subnormal when the directed mode rounds away from zero. Both cases raise `fx_uf` and `fx_nx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_is_dbl | input | 1 | Source format: 1 binary64, 0 binary32 |
| dst_is_dbl | input | 1 | Destination format: 1 binary64, 0 binary32 |
| rnd_mode | input | 3 | Rounding mode used when narrowing |
| opnd | input | 64 | Source register value |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Destination register value |
| fx_nv | output | 1 | Invalid operation flag |
| fx_of | output | 1 | Overflow flag |
| fx_uf | output | 1 | Underflow flag |
| fx_nx | output | 1 | Inexact flag |

## Verification
Every result and all four flags are due on the first rising edge after the request, so they are never expected in the same cycle as the request. The bench drives each request on a falling edge. It checks that request's outputs on the next falling edge, just before it drives the next request, against a behavioural model that narrows by shifting one bit at a time and widens by normalizing in a loop. In cycles with no request, the same falling-edge check expects `out_valid` low and the last result and flags unchanged.

// File: rtl/fpcvt_sd.sv
module fpcvt_sd (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        src_is_dbl,
  input  logic        dst_is_dbl,
  input  logic [2:0]  rnd_mode,
  input  logic [63:0] opnd,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        fx_nv,
  output logic        fx_of,
  output logic        fx_uf,
  output logic        fx_nx
);
  localparam logic [31:0] QNAN_S = 32'h7FC0_0000;
  localparam logic [63:0] QNAN_D = 64'h7FF8_0000_0000_0000;
  localparam logic [31:0] BOX    = 32'hFFFF_FFFF;

  // widening path
  logic        w_boxed;
  logic [31:0] w_src;
  logic        w_s;
  logic [7:0]  w_e;
  logic [22:0] w_f;
  logic [4:0]  w_lz;
  logic [22:0] w_norm;
  logic [63:0] w_res;
  logic        w_nv;

  assign w_boxed = &opnd[63:32];
  assign w_src   = w_boxed ? opnd[31:0] : QNAN_S;
  assign w_s     = w_src[31];
  assign w_e     = w_src[30:23];
  assign w_f     = w_src[22:0];

  always_comb begin
    w_lz = 5'd0;
    for (int i = 0; i < 23; i++)
      if (w_f[i]) w_lz = 5'(22 - i);
  end

  assign w_norm = 23'(w_f << (w_lz + 5'd1));

  always_comb begin
    w_nv = 1'b0;
    if (w_e == 8'hFF) begin
      if (w_f == '0) w_res = {w_s, 11'h7FF, 52'd0};
      else begin
        w_res = QNAN_D;
        w_nv  = ~w_f[22];
      end
    end else if (w_e == 8'h00) begin
      if (w_f == '0) w_res = {w_s, 63'd0};
      else           w_res = {w_s, 11'(11'd896 - {6'd0, w_lz}), w_norm, 29'd0};
    end else begin
      w_res = {w_s, {3'd0, w_e} + 11'd896, w_f, 29'd0};
    end
  end

  // narrowing path
  logic               n_s;
  logic [10:0]        n_e;
  logic [51:0]        n_f;
  logic [52:0]        n_m;
  logic signed [12:0] n_es;
  logic               n_tiny;
  logic [11:0]        n_subsh;
  logic [5:0]         n_sh;
  logic [107:0]       n_wide;
  logic [22:0]        n_q;
  logic               n_g, n_st, n_inc, n_toinf;
  logic [30:0]        n_packed;
  logic [31:0]        n_sum;
  logic               n_ovf, n_inex;
  logic [31:0]        n_res;
  logic               n_of, n_uf, n_nx;

  assign n_s      = opnd[63];
  assign n_e      = opnd[62:52];
  assign n_f      = opnd[51:0];
  assign n_m      = {|n_e, n_f};
  assign n_es     = $signed({2'b00, n_e}) - 13'sd896;
  assign n_tiny   = n_es < 13'sd1;
  assign n_subsh  = 12'd926 - {1'b0, n_e};
  assign n_sh     = !n_tiny ? 6'd29 : (n_subsh > 12'd55 ? 6'd55 : n_subsh[5:0]);
  assign n_wide   = {n_m, 55'd0} >> n_sh;
  assign n_q      = n_wide[77:55];
  assign n_g      = n_wide[54];
  assign n_st     = |n_wide[53:0];
  assign n_inex   = n_g | n_st;
  assign n_packed = {n_tiny ? 8'd0 : n_es[7:0], n_q};

  always_comb begin
    case (rnd_mode)
      3'd0:    n_inc = n_g & (n_st | n_q[0]);
      3'd2:    n_inc = n_s & n_inex;
      3'd3:    n_inc = ~n_s & n_inex;
      3'd4:    n_inc = n_g;
      default: n_inc = 1'b0;
    endcase
    case (rnd_mode)
      3'd1:    n_toinf = 1'b0;
      3'd2:    n_toinf = n_s;
      3'd3:    n_toinf = ~n_s;
      default: n_toinf = 1'b1;
    endcase
  end

  assign n_sum = {1'b0, n_packed} + {31'd0, n_inc};
  assign n_ovf = !n_tiny && (n_es > 13'sd254 || n_sum[30:23] == 8'hFF);

  always_comb begin
    if (n_ovf) begin
      n_res = n_toinf ? {n_s, 8'hFF, 23'd0} : {n_s, 8'hFE, 23'h7F_FFFF};
      n_of  = 1'b1;
      n_uf  = 1'b0;
      n_nx  = 1'b1;
    end else begin
      n_res = {n_s, n_sum[30:0]};
      n_of  = 1'b0;
      n_uf  = n_tiny & n_inex;
      n_nx  = n_inex;
    end
  end

  // selection
  logic [63:0] c_res;
  logic        c_nv, c_of, c_uf, c_nx;

  always_comb begin
    c_res = '0;
    c_nv  = 1'b0;
    c_of  = 1'b0;
    c_uf  = 1'b0;
    c_nx  = 1'b0;
    if (src_is_dbl == dst_is_dbl) begin
      c_res = dst_is_dbl ? QNAN_D : {BOX, QNAN_S};
      c_nv  = 1'b1;
    end else if (!src_is_dbl) begin
      c_res = w_res;
      c_nv  = w_nv;
    end else if (rnd_mode > 3'd4) begin
      c_res = {BOX, QNAN_S};
      c_nv  = 1'b1;
    end else if (n_e == 11'h7FF) begin
      if (n_f == '0) c_res = {BOX, n_s, 8'hFF, 23'd0};
      else begin
        c_res = {BOX, QNAN_S};
        c_nv  = ~n_f[51];
      end
    end else begin
      c_res = {BOX, n_res};
      c_of  = n_of;
      c_uf  = n_uf;
      c_nx  = n_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      fx_nv     <= 1'b0;
      fx_of     <= 1'b0;
      fx_uf     <= 1'b0;
      fx_nx     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= c_res;
        fx_nv  <= c_nv;
        fx_of  <= c_of;
        fx_uf  <= c_uf;
        fx_nx  <= c_nx;
      end
    end
  end
endmodule

// File: rtl/fpcvt_sd_chk.sv
module fpcvt_sd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        src_is_dbl,
  input logic        dst_is_dbl,
  input logic [2:0]  rnd_mode,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        fx_nv,
  input logic        fx_of,
  input logic        fx_uf,
  input logic        fx_nx
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R1
  AST_NARROW_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_is_dbl && !dst_is_dbl |=> result[63:32] == 32'hFFFF_FFFF); // R6
  AST_WIDEN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !src_is_dbl && dst_is_dbl |=> !fx_nx && !fx_of && !fx_uf); // R3
  AST_OF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) fx_of |-> fx_nx); // R9
  AST_UF_INEXACT: assert property (@(posedge clk) disable iff (!rst_n) fx_uf |-> fx_nx); // R10
  AST_BAD_RM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_is_dbl && !dst_is_dbl && rnd_mode > 3'd4 |=>
    fx_nv && !fx_nx && result == 64'hFFFF_FFFF_7FC0_0000); // R8
  AST_SAME_FMT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_is_dbl == dst_is_dbl |=> fx_nv && !fx_of && !fx_uf && !fx_nx); // R2
endmodule

bind fpcvt_sd fpcvt_sd_chk chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_is_dbl(src_is_dbl),
  .dst_is_dbl(dst_is_dbl), .rnd_mode(rnd_mode), .out_valid(out_valid),
  .result(result), .fx_nv(fx_nv), .fx_of(fx_of), .fx_uf(fx_uf), .fx_nx(fx_nx)
);

// File: tb/fpcvt_sd_test.sv
module fpcvt_sd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        src_is_dbl = 1'b0;
  logic        dst_is_dbl = 1'b0;
  logic [2:0]  rnd_mode = 3'd0;
  logic [63:0] opnd = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        fx_nv, fx_of, fx_uf, fx_nx;

  always #10 clk = ~clk;

  fpcvt_sd uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_is_dbl(src_is_dbl),
    .dst_is_dbl(dst_is_dbl), .rnd_mode(rnd_mode), .opnd(opnd),
    .out_valid(out_valid), .result(result),
    .fx_nv(fx_nv), .fx_of(fx_of), .fx_uf(fx_uf), .fx_nx(fx_nx)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit          p_v = 0;
  logic [63:0] p_r = '0;
  logic [3:0]  p_fl = '0;
  string       p_tag = "R1";
  logic [63:0] h_r = '0;
  logic [3:0]  h_fl = '0;

  localparam logic [63:0] CAN_D = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] CAN_SB = 64'hFFFF_FFFF_7FC0_0000;

  function automatic void widen_model(input logic [63:0] op, output logic [63:0] r,
                                      output logic [3:0] fl, output string tag);
    logic [31:0] lo;
    longint unsigned m;
    int ex;
    fl = 4'b0000; tag = "R3";
    if (op[63:32] != 32'hFFFF_FFFF) begin
      r = CAN_D; tag = "R4"; return;
    end
    lo = op[31:0];
    if (lo[30:23] == 8'hFF) begin
      if (lo[22:0] == 0) r = {lo[31], 11'h7FF, 52'd0};
      else begin r = CAN_D; fl[3] = ~lo[22]; tag = "R5"; end
    end else if (lo[30:23] == 0) begin
      if (lo[22:0] == 0) r = {lo[31], 63'd0};
      else begin
        m = longint'(lo[22:0]); ex = -126;
        while (m < (64'd1 << 23)) begin m = m << 1; ex--; end
        m = m - (64'd1 << 23);
        r = {lo[31], 11'(ex + 1023), m[22:0], 29'd0};
      end
    end else r = {lo[31], 11'(lo[30:23] + 896), lo[22:0], 29'd0};
  endfunction

  function automatic void narrow_model(input logic [63:0] op, input logic [2:0] rm,
                                       output logic [63:0] r, output logic [3:0] fl,
                                       output string tag);
    logic s;
    logic [10:0] e;
    longint unsigned k;
    int ex, p, etop, q, sh, expf;
    bit g, st, inc, tiny, toinf;
    fl = 4'b0000; tag = "R7 R6";
    s = op[63]; e = op[62:52];
    if (rm > 4) begin r = CAN_SB; fl[3] = 1; tag = "R8"; return; end
    if (e == 11'h7FF) begin
      if (op[51:0] == 0) r = {32'hFFFF_FFFF, s, 8'hFF, 23'd0};
      else begin r = CAN_SB; fl[3] = ~op[51]; tag = "R5"; end
      return;
    end
    if (e == 0 && op[51:0] == 0) begin r = {32'hFFFF_FFFF, s, 31'd0}; return; end
    if (e == 0) begin k = longint'(op[51:0]); ex = -1074; tag = "R11"; end
    else begin k = (64'd1 << 52) | longint'(op[51:0]); ex = int'(e) - 1075; end
    p = 52;
    while (k[p] == 1'b0) p--;
    etop = ex + p;
    tiny = etop < -126;
    q = tiny ? -149 : etop - 23;
    if (tiny && e != 0) tag = "R10";
    sh = q - ex;
    g = 0; st = 0;
    for (int i = 0; i < sh; i++) begin st = st | g; g = k[0]; k = k >> 1; end
    case (rm)
      3'd0: inc = g && (st || k[0]);
      3'd1: inc = 0;
      3'd2: inc = s && (g || st);
      3'd3: inc = !s && (g || st);
      default: inc = g;
    endcase
    k = k + longint'(inc);
    if (!tiny && k == (64'd1 << 24)) begin k = 64'd1 << 23; q++; end
    if (k >= (64'd1 << 23)) begin expf = q + 150; k = k - (64'd1 << 23); end
    else expf = 0;
    if (expf >= 255) begin
      toinf = (rm == 0 || rm == 4 || (rm == 2 && s) || (rm == 3 && !s));
      r = toinf ? {32'hFFFF_FFFF, s, 8'hFF, 23'd0} : {32'hFFFF_FFFF, s, 8'hFE, 23'h7F_FFFF};
      fl = 4'b0101; tag = "R9";
      return;
    end
    r = {32'hFFFF_FFFF, s, 8'(expf), k[22:0]};
    fl[0] = g | st;
    fl[1] = tiny & (g | st);
  endfunction

  // flags order {nv, of, uf, nx}
  task automatic check_out();
    logic [3:0] fl;
    fl = {fx_nv, fx_of, fx_uf, fx_nx};
    total++;
    if (p_v) begin
      if (out_valid !== 1'b1 || result !== p_r || fl !== p_fl) begin
        bad++;
        $display("FAIL %s: got v=%b r=%h fl=%b exp v=1 r=%h fl=%b", p_tag, out_valid, result, fl, p_r, p_fl);
      end
      h_r = p_r; h_fl = p_fl;
    end else begin
      if (out_valid !== 1'b0 || result !== h_r || fl !== h_fl) begin
        bad++;
        $display("FAIL R1 idle: got v=%b r=%h fl=%b exp v=0 r=%h fl=%b", out_valid, result, fl, h_r, h_fl);
      end
    end
  endtask

  task automatic drive(input bit v, input bit s, input bit d, input logic [2:0] rm, input logic [63:0] op);
    @(negedge clk);
    check_out();
    in_valid = v; src_is_dbl = s; dst_is_dbl = d; rnd_mode = rm; opnd = op;
    p_v = v;
    if (v) begin
      if (s == d) begin
        p_r = d ? CAN_D : CAN_SB; p_fl = 4'b1000; p_tag = "R2";
      end else if (!s) widen_model(op, p_r, p_fl, p_tag);
      else narrow_model(op, rm, p_r, p_fl, p_tag);
    end
  endtask

  task automatic widen(input logic [31:0] v32);
    drive(1, 0, 1, 3'(total % 8), {32'hFFFF_FFFF, v32});
  endtask

  task automatic narrow_all(input logic [63:0] v64);
    for (int m = 0; m < 5; m++) drive(1, 1, 0, 3'(m), v64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || result !== 64'd0 || {fx_nv, fx_of, fx_uf, fx_nx} !== 4'b0) begin
      bad++;
      $display("FAIL R1 reset: got v=%b r=%h exp v=0 r=0", out_valid, result);
    end
    rst_n = 1'b1;

    widen(32'h3F80_0000);
    widen(32'hC020_0000);
    widen(32'h0000_0001);
    widen(32'h807F_FFFF);
    widen(32'h7F80_0000);
    widen(32'hFF80_0000);
    widen(32'h8000_0000);
    widen(32'h7FC0_0001);
    widen(32'hFF80_0001);
    widen(32'h7F7F_FFFF);
    drive(1, 0, 1, 3'd7, 64'hFFFF_FFFF_3F80_0000);
    drive(1, 0, 1, 3'd0, 64'h0000_0000_4000_0000);
    drive(1, 0, 1, 3'd0, 64'h7FFF_FFFF_3F80_0000);
    drive(0, 0, 1, 3'd0, 64'd0);
    drive(0, 0, 0, 3'd0, 64'd0);
    drive(1, 0, 0, 3'd0, 64'hFFFF_FFFF_3F80_0000);
    drive(1, 1, 1, 3'd0, 64'h3FF0_0000_0000_0000);

    narrow_all(64'h3FF0_0000_0000_0000);
    narrow_all(64'h4009_21FB_5444_2D18);
    narrow_all(64'hC009_21FB_5444_2D18);
    narrow_all(64'h3FF0_0000_1000_0000);
    narrow_all(64'h3FF0_0000_3000_0000);
    narrow_all(64'h7E37_E43C_8800_759C);
    narrow_all(64'hFE37_E43C_8800_759C);
    narrow_all(64'h47EF_FFFF_F000_0000);
    narrow_all(64'h47EF_FFFF_E000_0000);
    narrow_all(64'h3690_0000_0000_0000);
    narrow_all(64'h3690_0000_0000_0001);
    narrow_all(64'hB6A8_0000_0000_0000);
    narrow_all(64'h380F_FFFF_F000_0000);
    narrow_all(64'h0000_0000_0000_0001);
    narrow_all(64'h8000_0000_0000_0001);
    narrow_all(64'h8000_0000_0000_0000);
    narrow_all(64'hFFF0_0000_0000_0000);
    narrow_all(64'h7FF8_0000_0000_0001);
    narrow_all(64'h7FF0_0000_0000_0001);
    for (int m = 5; m < 8; m++) drive(1, 1, 0, 3'(m), 64'h3FF0_0000_0000_0000);

    for (int i = 0; i < 600; i++) begin
      logic [63:0] op;
      logic [10:0] e;
      op = {$urandom(), $urandom()};
      case (i % 6)
        0: e = 11'(850 + $urandom_range(0, 310));
        1: e = 11'(880 + $urandom_range(0, 30));
        2: e = 11'(1140 + $urandom_range(0, 20));
        3: e = 11'($urandom_range(0, 3));
        4: e = 11'(896 + $urandom_range(0, 256));
        default: e = op[62:52];
      endcase
      op[62:52] = e;
      if (i % 7 == 0) op[28:0] = 29'h1000_0000;
      if (i % 4 == 3) drive(1, 0, 1, 3'($urandom_range(0, 7)), {(i % 8 == 3) ? 32'h0 : 32'hFFFF_FFFF, op[31:0]});
      else drive(1, 1, 0, 3'($urandom_range(0, 4)), op);
      if (i % 11 == 0) drive(0, 1, 0, 3'd0, op);
    end
    drive(0, 0, 0, 3'd0, 64'd0);
    drive(0, 0, 0, 3'd0, 64'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: got no end exp end of run");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule